// File: doc/BRIEF.md
# Buffer and Record Sync Sequencer

This block sequences a streaming output engine that plays data out of two memory buffers used in turn, each buffer holding a run of records (or messages). It decides when the first buffer begins after the output is enabled, when playback moves to the other buffer, and when each record begins. It does not move any data. The data path reports end-of-buffer and end-of-record strobes. The sequencer answers with single-cycle start-buffer, switch-buffer and start-record pulses, and it keeps the index of the active buffer.

Buffer changes follow one of four behaviours: immediately at end-of-buffer, after a programmed idle gap, on a chosen edge of an external buffer sync input, or on edges of that input whose polarity alternates. Record starts have three behaviours: immediate, after a gap, or on a chosen edge of an external record sync input. Both sync inputs are asynchronous. Each passes through a two-flop synchronizer, and a further flop holds the previous sample for edge detection. In message mode the buffer behaviour is forced to the immediate one.

The buffer controller has five states:
- IDLE: the output is disabled.
- WAIT_FIRST: waiting for the first qualifying sync edge.
- RUN: a buffer is playing.
- GAP: counting the buffer gap.
- ARMED: end-of-buffer has been seen and the controller waits for a sync edge.

Its transitions:
- IDLE to RUN, with a start pulse, for the immediate and gap kinds.
- IDLE to WAIT_FIRST for the sync kinds.
- WAIT_FIRST to RUN on a qualifying edge.
- RUN to RUN, with a switch pulse, on end-of-buffer in the immediate kind or with a zero gap.
- RUN to GAP on end-of-buffer with a non-zero gap.
- GAP to RUN, with a switch pulse, when the count is used up.
- RUN to ARMED on end-of-buffer in the sync kinds.
- ARMED to RUN, with a switch pulse, on a qualifying edge.
- Any state to IDLE when output enable is low.

The record controller has the states IDLE, WAIT_SYNC, RUN and GAP. Its transitions are the same, with WAIT_SYNC taking the part of both WAIT_FIRST and ARMED.

Top module: `bufrec_sequencer`

## Requirements
- R1: While reset is asserted, and on the first cycles after it with `out_en` low, `start_buf`, `switch_buf` and `start_rec` are 0 and `buf_idx` is 0.
- R2: `buf_mode` 000 or 010 ignores `buf_sync`. `start_buf` pulses one cycle after the clock edge that first samples `out_en` high. `switch_buf` pulses one cycle after the edge that samples `eob` high.
- R3: `buf_mode` 001 or 011 ignores `buf_sync` and starts like R2. After the edge that samples `eob`, the switch pulse comes `buf_gap` cycles later than in R2; a gap of 0 gives the same timing as R2.
- R4: `buf_mode` 100 uses rising edges of `buf_sync` and 101 uses falling edges. Edges of the other polarity are ignored. The first `start_buf` waits for a qualifying edge after enable. A `buf_sync` level change made before clock edge k produces its pulse in the cycle after edge k+2.
- R5: In the sync buffer modes, a `buf_sync` edge that arrives while a buffer plays, before `eob`, is ignored. `eob` alone does not switch. The switch takes place on the first qualifying edge after `eob`.
- R6: `buf_mode` 110 and 111 take edges of alternating polarity. Mode 110 starts on a rising edge and mode 111 starts on a falling edge. Each edge that is taken reverses the polarity expected next.
- R7: With `msg_mode` high, every `buf_mode` value behaves as 000.
- R8: `rec_mode` 00 ignores `rec_sync`. `start_rec` pulses one cycle after the edge that first samples `out_en` high, and one cycle after each edge that samples `eor`.
- R9: `rec_mode` 01 starts the first record as R8 does. After `eor`, `start_rec` comes `rec_gap` cycles later than in R8.
- R10: `rec_mode` 10 starts every record, the first included, on a rising `rec_sync` edge, and 11 on a falling edge. The latency is as in R4. Edges before `eor`, and edges of the wrong polarity, are ignored.
- R11: `out_en` low returns both controllers to idle within one cycle. It cancels any gap or edge wait, clears `buf_idx` to 0, and resets the alternating polarity to the mode's first polarity.
- R12: `start_buf` pulses at most once per enable period and never in the same cycle as `switch_buf`. `buf_idx` is 0 from the start and inverts with every `switch_buf` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| out_en | input | 1 | Output enable; low forces idle |
| msg_mode | input | 1 | Message mode; forces immediate buffer switching |
| buf_mode | input | 3 | Buffer sync mode |
| rec_mode | input | 2 | Record sync mode |
| buf_gap | input | GAP_W | Idle cycles before a buffer switch in gap mode |
| rec_gap | input | GAP_W | Idle cycles before a record start in gap mode |
| eob | input | 1 | End-of-buffer strobe from the data path |
| eor | input | 1 | End-of-record or end-of-message strobe |
| buf_sync | input | 1 | Asynchronous buffer sync input |
| rec_sync | input | 1 | Asynchronous record sync input |
| start_buf | output | 1 | One-cycle pulse: the first buffer begins |
| switch_buf | output | 1 | One-cycle pulse: playback moves to the other buffer |
| buf_idx | output | 1 | Index of the active buffer |
| start_rec | output | 1 | One-cycle pulse: a record begins |

## Verification
The bench measures the latency from each trigger to its pulse. A design that counts the gap one cycle too many or too few, or that adds or loses a synchronizer stage, shows up as a latency that is off by one. The bench also sends edges of the wrong polarity, and edges that arrive before the end marker. A design that reacts to either of these produces a start or a switch during a window where it must be silent.

The bench re-enables the output after a disable in which a polarity has already been taken. A design that does not restore the expected polarity waits forever for the wrong edge. A gap that is cancelled by disabling the output must never produce a late switch pulse, and message mode must override even the sync buffer codes.

// File: rtl/bufrec_pkg.sv
package bufrec_pkg;

    // How a controller decides when to move on
    typedef enum logic [1:0] {
        K_FREE,   // at the end marker
        K_GAP,    // a programmed number of cycles after the end marker
        K_EDGE,   // on one fixed sync polarity
        K_ALT     // on sync edges of alternating polarity
    } trig_kind_e;

    typedef enum logic [2:0] {
        B_IDLE,
        B_WAIT_FIRST,
        B_RUN,
        B_GAP,
        B_ARMED
    } buf_state_e;

    typedef enum logic [1:0] {
        R_IDLE,
        R_WAIT_SYNC,
        R_RUN,
        R_GAP
    } rec_state_e;

    function automatic trig_kind_e buf_kind(input logic [2:0] mode, input logic msg);
        if (msg)
            return K_FREE;
        if (!mode[2])
            return mode[0] ? K_GAP : K_FREE;
        return mode[1] ? K_ALT : K_EDGE;
    endfunction

    function automatic trig_kind_e rec_kind(input logic [1:0] mode);
        case (mode)
            2'b00:   return K_FREE;
            2'b01:   return K_GAP;
            default: return K_EDGE;
        endcase
    endfunction

    // Even codes in the edge-driven ranges start on a rising edge
    function automatic logic first_is_rise(input logic lsb);
        return ~lsb;
    endfunction

endpackage

// File: rtl/seq_sync_edge.sv
module seq_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);

    // STAGES synchronizer flops plus one history flop
    logic [STAGES:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            chain <= '0;
        else
            chain <= {chain[STAGES-1:0], din};
    end

    assign rise =  chain[STAGES-1] & ~chain[STAGES];
    assign fall = ~chain[STAGES-1] &  chain[STAGES];

endmodule

// File: rtl/seq_gap_timer.sv
module seq_gap_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (dec && cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/seq_buf_fsm.sv
module seq_buf_fsm
    import bufrec_pkg::*;
#(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             out_en,
    input  trig_kind_e       kind,
    input  logic             first_rise,
    input  logic [GAP_W-1:0] gap,
    input  logic             eob,
    input  logic             sync_rise,
    input  logic             sync_fall,
    output logic             start_buf,
    output logic             switch_buf,
    output logic             buf_idx
);

    buf_state_e state, nxt;
    logic       expect_rise;
    logic       go_start, go_switch, took_edge;
    logic       t_load, t_dec, t_zero;
    logic       sync_kind, want_rise, hit;

    assign sync_kind = (kind == K_EDGE) || (kind == K_ALT);
    assign want_rise = (kind == K_ALT) ? expect_rise : first_rise;
    assign hit       = sync_kind && (want_rise ? sync_rise : sync_fall);

    seq_gap_timer #(.W(GAP_W)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (gap - GAP_W'(1)),
        .dec      (t_dec),
        .zero     (t_zero)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= B_IDLE;
        else
            state <= nxt;
    end

    // Next state and transition events
    always_comb begin
        nxt       = state;
        go_start  = 1'b0;
        go_switch = 1'b0;
        took_edge = 1'b0;
        t_load    = 1'b0;
        t_dec     = 1'b0;
        if (!out_en) begin
            nxt = B_IDLE;
        end else begin
            unique case (state)
                B_IDLE: begin
                    if (sync_kind) begin
                        nxt = B_WAIT_FIRST;
                    end else begin
                        go_start = 1'b1;
                        nxt      = B_RUN;
                    end
                end
                B_WAIT_FIRST: begin
                    if (hit) begin
                        go_start  = 1'b1;
                        took_edge = 1'b1;
                        nxt       = B_RUN;
                    end
                end
                B_RUN: begin
                    if (eob) begin
                        if (sync_kind) begin
                            nxt = B_ARMED;
                        end else if (kind == K_GAP && gap != '0) begin
                            t_load = 1'b1;
                            nxt    = B_GAP;
                        end else begin
                            go_switch = 1'b1;
                        end
                    end
                end
                B_GAP: begin
                    if (t_zero) begin
                        go_switch = 1'b1;
                        nxt       = B_RUN;
                    end else begin
                        t_dec = 1'b1;
                    end
                end
                B_ARMED: begin
                    if (hit) begin
                        go_switch = 1'b1;
                        took_edge = 1'b1;
                        nxt       = B_RUN;
                    end
                end
                default: nxt = B_IDLE;
            endcase
        end
    end

    // Outputs and polarity tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_buf   <= 1'b0;
            switch_buf  <= 1'b0;
            buf_idx     <= 1'b0;
            expect_rise <= 1'b1;
        end else begin
            start_buf  <= go_start;
            switch_buf <= go_switch;
            if (!out_en || go_start)
                buf_idx <= 1'b0;
            else if (go_switch)
                buf_idx <= ~buf_idx;
            if (!out_en)
                expect_rise <= first_rise;
            else if (took_edge && kind == K_ALT)
                expect_rise <= ~expect_rise;
        end
    end

endmodule

// File: rtl/seq_rec_fsm.sv
module seq_rec_fsm
    import bufrec_pkg::*;
#(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             out_en,
    input  trig_kind_e       kind,
    input  logic             want_rise,
    input  logic [GAP_W-1:0] gap,
    input  logic             eor,
    input  logic             sync_rise,
    input  logic             sync_fall,
    output logic             start_rec
);

    rec_state_e state, nxt;
    logic       go_start;
    logic       t_load, t_dec, t_zero;
    logic       hit;

    assign hit = (kind == K_EDGE) && (want_rise ? sync_rise : sync_fall);

    seq_gap_timer #(.W(GAP_W)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (gap - GAP_W'(1)),
        .dec      (t_dec),
        .zero     (t_zero)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= R_IDLE;
        else
            state <= nxt;
    end

    // Next state and transition events
    always_comb begin
        nxt      = state;
        go_start = 1'b0;
        t_load   = 1'b0;
        t_dec    = 1'b0;
        if (!out_en) begin
            nxt = R_IDLE;
        end else begin
            unique case (state)
                R_IDLE: begin
                    if (kind == K_EDGE) begin
                        nxt = R_WAIT_SYNC;
                    end else begin
                        go_start = 1'b1;
                        nxt      = R_RUN;
                    end
                end
                R_WAIT_SYNC: begin
                    if (hit) begin
                        go_start = 1'b1;
                        nxt      = R_RUN;
                    end
                end
                R_RUN: begin
                    if (eor) begin
                        if (kind == K_EDGE) begin
                            nxt = R_WAIT_SYNC;
                        end else if (kind == K_GAP && gap != '0) begin
                            t_load = 1'b1;
                            nxt    = R_GAP;
                        end else begin
                            go_start = 1'b1;
                        end
                    end
                end
                R_GAP: begin
                    if (t_zero) begin
                        go_start = 1'b1;
                        nxt      = R_RUN;
                    end else begin
                        t_dec = 1'b1;
                    end
                end
                default: nxt = R_IDLE;
            endcase
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            start_rec <= 1'b0;
        else
            start_rec <= go_start;
    end

endmodule

// File: rtl/bufrec_sequencer.sv
module bufrec_sequencer
    import bufrec_pkg::*;
#(
    parameter int GAP_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             out_en,
    input  logic             msg_mode,
    input  logic [2:0]       buf_mode,
    input  logic [1:0]       rec_mode,
    input  logic [GAP_W-1:0] buf_gap,
    input  logic [GAP_W-1:0] rec_gap,
    input  logic             eob,
    input  logic             eor,
    input  logic             buf_sync,
    input  logic             rec_sync,
    output logic             start_buf,
    output logic             switch_buf,
    output logic             buf_idx,
    output logic             start_rec
);

    localparam int NUM_SYNC = 2;
    localparam int CH_BUF   = 0;
    localparam int CH_REC   = 1;

    logic [NUM_SYNC-1:0] sync_in, sync_rise, sync_fall;
    logic                buf_fall_w, rec_rise_w;
    trig_kind_e          bkind, rkind;

    assign sync_in[CH_BUF] = buf_sync;
    assign sync_in[CH_REC] = rec_sync;

    for (genvar c = 0; c < NUM_SYNC; c++) begin : g_sync
        seq_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (sync_in[c]),
            .rise  (sync_rise[c]),
            .fall  (sync_fall[c])
        );
    end

    assign bkind      = buf_kind(buf_mode, msg_mode);
    assign rkind      = rec_kind(rec_mode);
    assign buf_fall_w = sync_fall[CH_BUF];
    assign rec_rise_w = sync_rise[CH_REC];

    seq_buf_fsm #(.GAP_W(GAP_W)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .out_en     (out_en),
        .kind       (bkind),
        .first_rise (first_is_rise(buf_mode[0])),
        .gap        (buf_gap),
        .eob        (eob),
        .sync_rise  (sync_rise[CH_BUF]),
        .sync_fall  (sync_fall[CH_BUF]),
        .start_buf  (start_buf),
        .switch_buf (switch_buf),
        .buf_idx    (buf_idx)
    );

    seq_rec_fsm #(.GAP_W(GAP_W)) u_rec (
        .clk       (clk),
        .rst_n     (rst_n),
        .out_en    (out_en),
        .kind      (rkind),
        .want_rise (first_is_rise(rec_mode[0])),
        .gap       (rec_gap),
        .eor       (eor),
        .sync_rise (sync_rise[CH_REC]),
        .sync_fall (sync_fall[CH_REC]),
        .start_rec (start_rec)
    );

endmodule

// File: rtl/bufrec_sequencer_chk.sv
module bufrec_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       out_en,
    input logic       msg_mode,
    input logic [2:0] buf_mode,
    input logic [1:0] rec_mode,
    input logic       eob,
    input logic       start_buf,
    input logic       switch_buf,
    input logic       buf_idx,
    input logic       start_rec,
    input logic       buf_fall,
    input logic       rec_rise
);

    logic past_valid;
    logic started_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_valid <= 1'b0;
            started_q  <= 1'b0;
        end else begin
            past_valid <= 1'b1;
            if (!out_en)
                started_q <= 1'b0;
            else if (start_buf)
                started_q <= 1'b1;
        end
    end

    assert_disable_quiets_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |=> (!start_buf && !switch_buf && !start_rec));

    assert_free_switch_on_eob_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && switch_buf &&
         $past(out_en && (msg_mode || (!buf_mode[2] && !buf_mode[0])))) |-> $past(eob));

    assert_msg_switch_on_eob_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && switch_buf && $past(out_en && msg_mode)) |-> $past(eob));

    assert_fall_mode_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && (start_buf || switch_buf) &&
         $past(out_en && !msg_mode && buf_mode == 3'b101)) |-> $past(buf_fall));

    assert_rec_rise_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && start_rec && $past(out_en && rec_mode == 2'b10)) |-> $past(rec_rise));

    assert_start_not_switch_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_buf && switch_buf));

    assert_single_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
        start_buf |-> !started_q);

    assert_idx_moves_on_switch_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && buf_idx != $past(buf_idx)) |-> (switch_buf || !$past(out_en)));

endmodule

bind bufrec_sequencer bufrec_sequencer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .out_en     (out_en),
    .msg_mode   (msg_mode),
    .buf_mode   (buf_mode),
    .rec_mode   (rec_mode),
    .eob        (eob),
    .start_buf  (start_buf),
    .switch_buf (switch_buf),
    .buf_idx    (buf_idx),
    .start_rec  (start_rec),
    .buf_fall   (buf_fall_w),
    .rec_rise   (rec_rise_w)
);

// File: tb/sim_bufrec_sequencer.sv
module sim_bufrec_sequencer;

    localparam int GAP_W = 8;
    localparam int T_EN = 0, T_EOB = 1, T_EOR = 2, T_BSYNC = 3, T_RSYNC = 4;
    localparam int S_START = 0, S_SW = 1, S_REC = 2;

    typedef struct packed {
        logic [2:0] mode;
        logic       msg;
        logic [7:0] gap;
        logic [7:0] st_lat;
        logic [7:0] sw_lat;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{3'b000, 1'b0, 8'd0, 8'd1, 8'd1},
        '{3'b010, 1'b0, 8'd5, 8'd1, 8'd1},
        '{3'b001, 1'b0, 8'd0, 8'd1, 8'd1},
        '{3'b001, 1'b0, 8'd3, 8'd1, 8'd4},
        '{3'b011, 1'b0, 8'd7, 8'd1, 8'd8},
        '{3'b100, 1'b1, 8'd4, 8'd1, 8'd1},
        '{3'b111, 1'b1, 8'd0, 8'd1, 8'd1},
        '{3'b001, 1'b1, 8'd6, 8'd1, 8'd1}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             out_en = 1'b0;
    logic             msg_mode = 1'b0;
    logic [2:0]       buf_mode = 3'b000;
    logic [1:0]       rec_mode = 2'b00;
    logic [GAP_W-1:0] buf_gap = '0;
    logic [GAP_W-1:0] rec_gap = '0;
    logic             eob = 1'b0;
    logic             eor = 1'b0;
    logic             buf_sync = 1'b0;
    logic             rec_sync = 1'b0;
    logic             start_buf, switch_buf, buf_idx, start_rec;

    int nchk = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    bufrec_sequencer #(.GAP_W(GAP_W)) u0 (
        .clk(clk), .rst_n(rst_n), .out_en(out_en), .msg_mode(msg_mode),
        .buf_mode(buf_mode), .rec_mode(rec_mode), .buf_gap(buf_gap), .rec_gap(rec_gap),
        .eob(eob), .eor(eor), .buf_sync(buf_sync), .rec_sync(rec_sync),
        .start_buf(start_buf), .switch_buf(switch_buf), .buf_idx(buf_idx),
        .start_rec(start_rec)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic get_out(input int sel);
        case (sel)
            S_START: return start_buf;
            S_SW:    return switch_buf;
            default: return start_rec;
        endcase
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Apply a trigger at the current negedge, count negedges until the pulse
    task automatic fire(input int trig, input int sel, output int lat);
        case (trig)
            T_EN:    out_en = 1'b1;
            T_EOB:   eob = 1'b1;
            T_EOR:   eor = 1'b1;
            T_BSYNC: buf_sync = ~buf_sync;
            default: rec_sync = ~rec_sync;
        endcase
        lat = 99;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            eob = 1'b0;
            eor = 1'b0;
            if (get_out(sel)) begin
                lat = i + 1;
                break;
            end
        end
    endtask

    task automatic quiet(input int sel, input int n, output int seen);
        seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            eob = 1'b0;
            eor = 1'b0;
            if (get_out(sel)) seen++;
        end
    endtask

    task automatic pulse(input int trig);
        if (trig == T_EOB) eob = 1'b1; else eor = 1'b1;
        @(negedge clk);
        eob = 1'b0;
        eor = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        nfail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int lat;
        int seen;
        string tag;

        // R1: reset state
        idle(3);
        check(start_buf == 0 && switch_buf == 0 && start_rec == 0, "R1", 32'(start_buf | switch_buf | start_rec), 0);
        check(buf_idx == 0, "R1", 32'(buf_idx), 0);
        rst_n = 1'b1;
        quiet(S_START, 4, seen);
        check(seen == 0, "R1", seen, 0);
        check(buf_idx == 0 && start_rec == 0, "R1", 32'(buf_idx | start_rec), 0);

        // Vector table: immediate, gap and message-mode buffer switching
        for (int i = 0; i < 8; i++) begin
            tag = VECS[i].msg ? "R7" : (VECS[i].mode[0] ? "R3" : "R2");
            out_en   = 1'b0;
            buf_mode = VECS[i].mode;
            msg_mode = VECS[i].msg;
            buf_gap  = VECS[i].gap;
            rec_mode = 2'b00;
            idle(4);
            fire(T_EN, S_START, lat);
            check(lat == int'(VECS[i].st_lat), tag, lat, int'(VECS[i].st_lat));
            check(buf_idx == 0, "R12", 32'(buf_idx), 0);
            idle(2);
            fire(T_EOB, S_SW, lat);
            check(lat == int'(VECS[i].sw_lat), tag, lat, int'(VECS[i].sw_lat));
            check(buf_idx == 1, "R12", 32'(buf_idx), 1);
            idle(2);
            fire(T_EOB, S_SW, lat);
            check(lat == int'(VECS[i].sw_lat), tag, lat, int'(VECS[i].sw_lat));
            check(buf_idx == 0, "R12", 32'(buf_idx), 0);
        end
        msg_mode = 1'b0;

        // R4/R5: rising-edge mode
        out_en = 1'b0; buf_mode = 3'b100; idle(4);
        out_en = 1'b1;
        quiet(S_START, 6, seen);
        check(seen == 0, "R4", seen, 0);
        fire(T_BSYNC, S_START, lat);
        check(lat == 3, "R4", lat, 3);
        check(buf_idx == 0, "R12", 32'(buf_idx), 0);
        buf_sync = 1'b0;
        quiet(S_SW, 6, seen);
        buf_sync = 1'b1;
        quiet(S_SW, 6, seen);
        check(seen == 0, "R5", seen, 0);
        buf_sync = 1'b0; idle(4);
        pulse(T_EOB);
        quiet(S_SW, 6, seen);
        check(seen == 0, "R5", seen, 0);
        fire(T_BSYNC, S_SW, lat);
        check(lat == 3, "R5", lat, 3);
        check(buf_idx == 1, "R12", 32'(buf_idx), 1);

        // R4: falling-edge mode
        out_en = 1'b0; buf_mode = 3'b101; idle(4);
        out_en = 1'b1; idle(4);
        fire(T_BSYNC, S_START, lat);
        check(lat == 3, "R4", lat, 3);
        pulse(T_EOB);
        buf_sync = 1'b1;
        quiet(S_SW, 6, seen);
        check(seen == 0, "R4", seen, 0);
        fire(T_BSYNC, S_SW, lat);
        check(lat == 3, "R4", lat, 3);
        check(buf_idx == 1, "R12", 32'(buf_idx), 1);

        // R6: alternating, first rising
        out_en = 1'b0; buf_mode = 3'b110; idle(4);
        out_en = 1'b1; idle(2);
        fire(T_BSYNC, S_START, lat);
        check(lat == 3, "R6", lat, 3);
        pulse(T_EOB);
        fire(T_BSYNC, S_SW, lat);
        check(lat == 3, "R6", lat, 3);
        check(buf_idx == 1, "R6", 32'(buf_idx), 1);
        pulse(T_EOB);
        fire(T_BSYNC, S_SW, lat);
        check(lat == 3, "R6", lat, 3);
        check(buf_idx == 0, "R6", 32'(buf_idx), 0);

        // R6: alternating, first falling
        out_en = 1'b0; buf_mode = 3'b111; buf_sync = 1'b0; idle(5);
        out_en = 1'b1; idle(2);
        buf_sync = 1'b1;
        quiet(S_START, 6, seen);
        check(seen == 0, "R6", seen, 0);
        fire(T_BSYNC, S_START, lat);
        check(lat == 3, "R6", lat, 3);
        pulse(T_EOB);
        fire(T_BSYNC, S_SW, lat);
        check(lat == 3, "R6", lat, 3);
        check(buf_idx == 1, "R6", 32'(buf_idx), 1);

        // R11: disabling cancels a gap in progress
        out_en = 1'b0; buf_mode = 3'b001; buf_gap = 8'd20; idle(3);
        fire(T_EN, S_START, lat);
        check(lat == 1, "R3", lat, 1);
        pulse(T_EOB);
        idle(5);
        out_en = 1'b0;
        quiet(S_SW, 30, seen);
        check(seen == 0, "R11", seen, 0);
        check(buf_idx == 0, "R11", 32'(buf_idx), 0);

        // R11: alternating polarity restored after disable
        buf_mode = 3'b110; buf_sync = 1'b0; idle(5);
        out_en = 1'b1; idle(2);
        fire(T_BSYNC, S_START, lat);
        check(lat == 3, "R6", lat, 3);
        out_en = 1'b0; idle(2);
        buf_sync = 1'b0; idle(5);
        out_en = 1'b1; idle(2);
        fire(T_BSYNC, S_START, lat);
        check(lat == 3, "R11", lat, 3);

        // R8: immediate records
        out_en = 1'b0; buf_mode = 3'b000; rec_mode = 2'b00; idle(3);
        fire(T_EN, S_REC, lat);
        check(lat == 1, "R8", lat, 1);
        idle(2);
        fire(T_EOR, S_REC, lat);
        check(lat == 1, "R8", lat, 1);

        // R9: record gap
        out_en = 1'b0; rec_mode = 2'b01; rec_gap = 8'd4; idle(3);
        fire(T_EN, S_REC, lat);
        check(lat == 1, "R9", lat, 1);
        idle(2);
        fire(T_EOR, S_REC, lat);
        check(lat == 5, "R9", lat, 5);
        rec_gap = 8'd0; idle(2);
        fire(T_EOR, S_REC, lat);
        check(lat == 1, "R9", lat, 1);

        // R10: record rising edge
        out_en = 1'b0; rec_mode = 2'b10; rec_sync = 1'b0; idle(4);
        out_en = 1'b1;
        quiet(S_REC, 6, seen);
        check(seen == 0, "R10", seen, 0);
        fire(T_RSYNC, S_REC, lat);
        check(lat == 3, "R10", lat, 3);
        pulse(T_EOR);
        rec_sync = 1'b0;
        quiet(S_REC, 6, seen);
        check(seen == 0, "R10", seen, 0);
        fire(T_RSYNC, S_REC, lat);
        check(lat == 3, "R10", lat, 3);

        // R10: record falling edge
        out_en = 1'b0; rec_mode = 2'b11; idle(4);
        out_en = 1'b1; idle(2);
        fire(T_RSYNC, S_REC, lat);
        check(lat == 3, "R10", lat, 3);
        pulse(T_EOR);
        rec_sync = 1'b1;
        quiet(S_REC, 6, seen);
        check(seen == 0, "R10", seen, 0);
        fire(T_RSYNC, S_REC, lat);
        check(lat == 3, "R10", lat, 3);

        out_en = 1'b0;
        idle(3);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule